// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps activity on an external input. On each selected event it copies the current value of a free-running 16-bit timer into a capture register, and it raises a sticky interrupt flag. A 4-bit mode field chooses the event. The event can be any falling edge, any rising edge, or one rising edge out of every four or every sixteen.

The pin is brought into the system clock domain by a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. For the divided modes, a 4-bit counter counts rising edges. This counter is cleared whenever the mode field holds a code that does not select capture. It keeps its count when software moves from one division ratio to another, so such a move can produce an early or late capture. Software is expected to clear the flag after any mode change.

The capture register can be read in two ways. It is driven out in full, and a byte-wide read port returns one byte of it. A new capture overwrites an unread value without any warning.

Top module: `icap_unit`

## Requirements
- R1: The mode field selects the capture event as follows: 4'b0100 captures on every falling edge, 4'b0101 on every rising edge, 4'b0110 on every 4th rising edge and 4'b0111 on every 16th rising edge. Every other code, including 4'b0000 (off), never captures.
- R2: A pin change driven between clock edges causes its capture on the third rising clock edge after the change. The capture register then holds the timer value present at that edge, all 16 bits loaded at once.
- R3: The interrupt flag is set by each capture. It stays set until a cycle in which the clear strobe is high and no capture happens, and it is low after that cycle.
- R4: When a capture and the clear strobe occur in the same cycle, the flag is set after that cycle.
- R5: A second capture replaces the stored value even if the first one was never read. The flag simply stays set.
- R6: In the divided modes, each rising edge adds one to the prescaler count. The capture fires on the edge that brings the count to the ratio (4 or 16), and the count returns to zero in that same cycle.
- R7: The prescaler count is zero after reset and after any cycle in which the mode field holds a code that is not a capture code.
- R8: Moving directly from one divided mode to the other keeps the count. When count plus one does not equal the selected ratio, the count advances modulo 16.
- R9: In the every-edge modes (4'b0100, 4'b0101), the prescaler count holds its value.
- R10: The read port returns capture bits 7:0 when the byte select is 0 and bits 15:8 when it is 1.
- R11: After reset, the capture register and the flag are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Raw level of the capture input |
| timer_i | input | 16 | Current value of the free-running timer |
| mode_i | input | 4 | Capture mode select |
| flag_clr_i | input | 1 | Software strobe that clears the interrupt flag |
| rd_sel_i | input | 1 | Byte select of the read port |
| rd_data_o | output | 8 | Selected byte of the capture register |
| cap_o | output | 16 | Full capture register |
| flag_o | output | 1 | Sticky capture interrupt flag |

## Verification
The two functions that can fall in the same cycle are a capture setting the flag and the software strobe clearing it. The bench provokes this directly by asserting the clear strobe in exactly the cycle where a synchronized rising edge is being captured. It expects the flag to remain set. Random stimulus also produces many such collisions, as well as captures that land right after mode changes. Each of these cases is judged against a cycle-level reference model in the bench that is built from the requirements.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [3:0] {
    MODE_OFF   = 4'b0000,
    MODE_FALL  = 4'b0100,
    MODE_RISE  = 4'b0101,
    MODE_DIV4  = 4'b0110,
    MODE_DIV16 = 4'b0111
  } icap_mode_e;

  function automatic logic is_capture(input logic [3:0] code);
    return (code == MODE_FALL) || (code == MODE_RISE) ||
           (code == MODE_DIV4) || (code == MODE_DIV16);
  endfunction

  function automatic logic is_divided(input logic [3:0] code);
    return (code == MODE_DIV4) || (code == MODE_DIV16);
  endfunction

endpackage

// File: rtl/icap_rst_sync.sv
module icap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_edge.sv
module icap_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   lvl;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        assign sync_d[g] = pin_i;
      end else begin : g_rest
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end

  always_comb begin
    rise_o = lvl & ~prev_q;
    fall_o = ~lvl & prev_q;
  end

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));  // R1
endmodule

// File: rtl/icap_presc.sv
module icap_presc
  import icap_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RATIO_A = 4,
  parameter int RATIO_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       fire_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] LIM_A = SUM_W'(RATIO_A);
  localparam logic [SUM_W-1:0] LIM_B = SUM_W'(RATIO_B);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] lim;

  always_comb begin
    sum    = {1'b0, cnt_q} + SUM_W'(1);
    lim    = (mode_i == MODE_DIV16) ? LIM_B : LIM_A;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    fire_o = 1'b0;
    if (!is_capture(mode_i)) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (mode_i == MODE_FALL) begin
      fire_o = fall_i;
    end else if (mode_i == MODE_RISE) begin
      fire_o = rise_i;
    end else if (rise_i) begin
      cnt_en = 1'b1;
      if (sum == lim) begin
        fire_o = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d  = sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_FIRE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (rise_i || fall_i));  // R1
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !is_capture(mode_i) |=> (cnt_q == '0));  // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && is_divided(mode_i)) |=> (cnt_q == '0));  // R6
  AST_EDGE_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FALL || mode_i == MODE_RISE) |=> $stable(cnt_q));  // R9
endmodule

// File: rtl/icap_store.sv
module icap_store #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic [TW-1:0] timer_i,
  input  logic          clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic [TW-1:0] cap_q, cap_d;
  logic          flag_q, flag_d;

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    if (fire_i) begin
      cap_d  = timer_i;
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (fire_i) cap_q <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  AST_CAP_LOADS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (cap_o == $past(timer_i)));  // R2
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(cap_o));  // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fire_i) |=> !flag_o);  // R3
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> flag_o);  // R4
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int RATIO_A     = 4,
  parameter int RATIO_B     = 16,
  localparam int NBYTES     = TW / BYTE_W,
  localparam int SEL_W      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              pin_i,
  input  logic [TW-1:0]     timer_i,
  input  logic [3:0]        mode_i,
  input  logic              flag_clr_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [TW-1:0]     cap_o,
  output logic              flag_o
);
  logic rst_n;
  logic rise, fall, fire;
  logic [BYTE_W-1:0] bytes [NBYTES];

  icap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  icap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  icap_presc #(.CNT_W(CNT_W), .RATIO_A(RATIO_A), .RATIO_B(RATIO_B)) u_presc (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rise_i(rise), .fall_i(fall), .fire_o(fire)
  );

  icap_store #(.TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .timer_i(timer_i),
    .clr_i(flag_clr_i), .cap_o(cap_o), .flag_o(flag_o)
  );

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign bytes[b] = cap_o[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_sel_i == SEL_W'(i)) rd_data_o = bytes[i];
    end
  end

  AST_FLAG_ONLY_BY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> !$stable(cap_o) || ($past(timer_i) == cap_o));  // R3
endmodule

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        pin;
  logic [15:0] timer;
  logic [3:0]  mode;
  logic        clr;
  logic        rd_sel;
  logic [7:0]  rd_data;
  logic [15:0] cap;
  logic        flag;
  logic        tmr_run;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  icap_unit dut (
    .clk(clk), .arst_n(arst_n), .pin_i(pin), .timer_i(timer),
    .mode_i(mode), .flag_clr_i(clr), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .cap_o(cap), .flag_o(flag)
  );

  // reference model built from the requirements
  logic        m_s1, m_s2, m_pv, m_flag;
  logic [3:0]  m_cnt;
  logic [15:0] m_cap;

  function automatic bit m_is_cap(input logic [3:0] c);
    return c == 4'b0100 || c == 4'b0101 || c == 4'b0110 || c == 4'b0111;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_pv <= 0; m_flag <= 0; m_cnt <= 0; m_cap <= 0;
    end else begin
      bit r, f, fire;
      logic [4:0] nx, lim;
      r = m_s2 && !m_pv;
      f = !m_s2 && m_pv;
      fire = 0;
      nx = {1'b0, m_cnt} + 5'd1;
      lim = (mode == 4'b0111) ? 5'd16 : 5'd4;
      if (!m_is_cap(mode)) m_cnt <= 0;
      else if (mode == 4'b0100) fire = f;
      else if (mode == 4'b0101) fire = r;
      else if (r) begin
        if (nx == lim) begin fire = 1; m_cnt <= 0; end
        else m_cnt <= nx[3:0];
      end
      if (fire) begin m_cap <= timer; m_flag <= 1; end
      else if (clr) m_flag <= 0;
      m_s1 <= pin; m_s2 <= m_s1; m_pv <= m_s2;
    end
  end

  always @(negedge clk) if (tmr_run) timer <= timer + 16'd1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    logic [7:0] eb;
    eb = rd_sel ? m_cap[15:8] : m_cap[7:0];
    chk(cap == m_cap, tag, 32'(cap), 32'(m_cap));
    chk(flag == m_flag, tag, 32'(flag), 32'(m_flag));
    chk(rd_data == eb, "R10", 32'(rd_data), 32'(eb));
  endtask

  task automatic pulse();
    pin = 1; repeat (4) @(negedge clk);
    pin = 0; repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic clear_flag();
    clr = 1; @(negedge clk); clr = 0; @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode = m; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    arst_n = 0; pin = 0; timer = 16'h0; mode = 4'b0000; clr = 0; rd_sel = 0; tmr_run = 1;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(cap == 16'h0, "R11", 32'(cap), 0);
    chk(flag == 1'b0, "R11", 32'(flag), 0);

    // R1 falling edge mode: rising half makes no capture, falling does
    set_mode(4'b0100);
    pin = 1; repeat (4) @(negedge clk);
    chk(flag == 0, "R1", 32'(flag), 0);
    pin = 0; repeat (4) @(negedge clk);
    chk(flag == 1, "R1", 32'(flag), 1);
    cmp_model("R2");
    // R3 clear
    clear_flag();
    chk(flag == 0, "R3", 32'(flag), 0);
    // R1 off code never captures
    set_mode(4'b0000); pulses(2);
    chk(flag == 0, "R1", 32'(flag), 0);
    set_mode(4'b0011); pulses(2);
    chk(flag == 0, "R1", 32'(flag), 0);

    // R6 divide by four
    set_mode(4'b0110);
    pulses(3);
    chk(flag == 0, "R6", 32'(flag), 0);
    pulse();
    chk(flag == 1, "R6", 32'(flag), 1);
    cmp_model("R6");
    clear_flag();

    // R7 leaving capture mode clears the count
    pulses(2);
    set_mode(4'b0000); set_mode(4'b0110);
    pulses(3);
    chk(flag == 0, "R7", 32'(flag), 0);
    pulse();
    chk(flag == 1, "R7", 32'(flag), 1);
    clear_flag();

    // R8 ratio switch keeps the count: 2 counted, then 14 more for sixteen
    pulses(2);
    set_mode(4'b0111);
    pulses(13);
    chk(flag == 0, "R8", 32'(flag), 0);
    pulse();
    chk(flag == 1, "R8", 32'(flag), 1);
    clear_flag();
    // R8 sixteen to four with count 10: wraps through 15 to 0
    pulses(10);
    set_mode(4'b0110);
    pulses(9);
    chk(flag == 0, "R8", 32'(flag), 0);
    pulse();
    chk(flag == 1, "R8", 32'(flag), 1);
    clear_flag();

    // R9 every-edge mode holds the count
    pulses(2);
    set_mode(4'b0101);
    pulse();
    chk(flag == 1, "R9", 32'(flag), 1);
    clear_flag();
    set_mode(4'b0110);
    pulse();
    chk(flag == 0, "R9", 32'(flag), 0);
    pulse();
    chk(flag == 1, "R9", 32'(flag), 1);
    clear_flag();

    // R4 clear strobe in the capture cycle
    set_mode(4'b0101);
    chk(flag == 0, "R4", 32'(flag), 0);
    pin = 1; @(negedge clk); @(negedge clk);
    clr = 1; @(negedge clk); clr = 0;
    chk(flag == 1, "R4", 32'(flag), 1);
    cmp_model("R4");
    pin = 0; repeat (4) @(negedge clk);

    // R5 overwrite of an unread value, R10 read port
    tmr_run = 0; timer = 16'hA5A5;
    pulse();
    chk(cap == 16'hA5A5, "R5", 32'(cap), 32'hA5A5);
    timer = 16'h1234;
    pulse();
    chk(cap == 16'h1234, "R5", 32'(cap), 32'h1234);
    chk(flag == 1, "R5", 32'(flag), 1);
    rd_sel = 0; #1;
    chk(rd_data == 8'h34, "R10", 32'(rd_data), 32'h34);
    rd_sel = 1; #1;
    chk(rd_data == 8'h12, "R10", 32'(rd_data), 32'h12);
    @(negedge clk);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cmp_model("R2");
      timer = 16'($urandom);
      if ($urandom_range(0, 2) == 0) pin = ~pin;
      clr = ($urandom_range(0, 7) == 0);
      rd_sel = 1'($urandom);
      if ($urandom_range(0, 63) == 0) begin
        case ($urandom_range(0, 6))
          0: mode = 4'b0000; 1: mode = 4'b0100; 2: mode = 4'b0101;
          3: mode = 4'b0110; 4: mode = 4'b0111; 5: mode = 4'b1111;
          default: mode = 4'b0011;
        endcase
      end
    end
    @(negedge clk);
    cmp_model("R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule